// File: doc/BRIEF.md
# Floating-Point Issue Port Dispatcher

This block holds a sixteen-slot scheduler window of 128-bit floating-point and SIMD micro-ops. Each cycle it sends up to four of them to four execution ports. The ports are not alike. Each port runs a fixed set of operation classes, and those sets partly overlap. The selection is therefore a constrained matching, not a plain "take the N oldest" pick. The ports are served in a fixed order, 0 then 1 then 2 then 3. Each port takes the oldest ready entry that it can run and that an earlier port has not already taken in the same cycle.

A producer writes one entry per cycle into a slot it names. The entry carries an age tag, a class code and an initial ready bit. A wake vector can later set the ready bits of waiting entries. The issue results are registered. The slot of an issued entry is released on the same edge that registers the result, so the producer may refill that slot on that edge. An entry with a class that no port runs is not accepted, and it sets a sticky error flag.

Top module: `fpd_dispatch`

## Requirements
- R1: At most one entry issues per port per cycle, up to four per cycle in total, and no two ports that are valid in the same cycle carry the same slot index.
- R2: Port 0 issues only these class codes: multiply 0, add 1, fused multiply-add 2, convert 3 and integer multiply-accumulate 4.
- R3: Port 1 issues only these class codes: multiply 0, add 1, fused multiply-add 2, shuffle 5 and permute 6.
- R4: Port 2 issues only these class codes: wide-vector 7, packed-integer 8 and integer-SSE 9.
- R5: Port 3 issues class codes 7, 8 and 9, plus floating-point store data 10.
- R6: The ports are filled in the order 0, 1, 2, 3. Each port takes the oldest valid, ready entry that it accepts and that a lower-numbered port has not taken this cycle. A port with no such entry stays idle.
- R7: Age is compared by wraparound-safe arithmetic: a is older than b when the top bit of the difference (a − b), taken modulo 2^AGE_W, is 1. This ordering holds across the counter wrapping from its maximum value to 0.
- R8: An issued entry leaves the window on the edge that registers its issue, and it never issues twice. A write to a slot on that same edge is kept. On the write edge the written slot takes its ready bit from `wr_rdy`. Any other valid slot becomes ready when its `wake_vec` bit is set.
- R9: A write with a class code of 11 to 15 creates no entry, so it is never issued. It sets `err` on that edge, and `err` stays set until reset.
- R10: During reset and just after it, `iss_vld` and `err` are 0 and the window is empty.
- R11: An entry that is written ready on edge e can first appear on the issue outputs after edge e+1. The outputs registered at an edge reflect the window contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | IDX_W | Slot that receives the entry |
| wr_age | input | AGE_W | Age tag of the entry |
| wr_cls | input | 4 | Class code of the entry |
| wr_rdy | input | 1 | Entry is ready when it is written |
| wake_vec | input | DEPTH | Set the ready bit of each marked slot |
| iss_vld | output | 4 | Issue valid, one bit per port |
| iss_idx | output | 4*IDX_W | Issued slot per port, port p at bits [p*IDX_W +: IDX_W] |
| iss_cls | output | 16 | Issued class per port, port p at bits [p*4 +: 4] |
| err | output | 1 | Sticky flag for an illegal class |

## Verification
The stimulus runs in phases, and each phase separates one kind of fault. A phase heavy in arithmetic classes makes ports 0 and 1 compete for the same shared classes, which exposes errors in the fill order and in the exclusion of already-taken slots. A phase heavy in vector classes does the same for ports 2 and 3, and it shows whether store data is kept off port 2. In the hold-then-release phase, entries wait unready until the window is full and are then woken together, so a wrong oldest-first choice shows up at once. Age tags start just below the wrap point, which separates a modular age compare from a plain magnitude compare. A phase that sprinkles in illegal classes confirms that such writes leave no entry behind and that the error flag stays set.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int NPORT = 4;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    C_FMUL = 4'd0, C_FADD = 4'd1, C_FMAC = 4'd2, C_FCVT = 4'd3,
    C_IMAC = 4'd4, C_SHUF = 4'd5, C_PERM = 4'd6, C_VEC  = 4'd7,
    C_PINT = 4'd8, C_ISSE = 4'd9, C_FSTD = 4'd10
  } op_cls_e;

  // bit p set when port p can execute class c
  function automatic logic [NPORT-1:0] legal_ports(input logic [CLS_W-1:0] c);
    case (c)
      C_FMUL, C_FADD, C_FMAC: legal_ports = 4'b0011;
      C_FCVT, C_IMAC:         legal_ports = 4'b0001;
      C_SHUF, C_PERM:         legal_ports = 4'b0010;
      C_VEC, C_PINT, C_ISSE:  legal_ports = 4'b1100;
      C_FSTD:                 legal_ports = 4'b1000;
      default:                legal_ports = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/fpd_entry_store.sv
module fpd_entry_store #(
  parameter int DEPTH = 16,
  parameter int AGE_W = 8,
  parameter int CLS_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [AGE_W-1:0]            wr_age,
  input  logic [CLS_W-1:0]            wr_cls,
  input  logic                        wr_rdy,
  input  logic [DEPTH-1:0]            wake_vec,
  input  logic [DEPTH-1:0]            clr_vec,
  output logic [DEPTH-1:0]            vld_q,
  output logic [DEPTH-1:0]            rdy_q,
  output logic [DEPTH-1:0][AGE_W-1:0] age_q,
  output logic [DEPTH-1:0][CLS_W-1:0] cls_q
);
  logic [DEPTH-1:0] hit;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= hit[i] | (vld_q[i] & ~clr_vec[i]);
        rdy_q[i] <= hit[i] ? wr_rdy : (rdy_q[i] | wake_vec[i]);
      end
    end
  end

  // payload needs no reset: it is qualified by vld_q
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) begin
        age_q[i] <= wr_age;
        cls_q[i] <= wr_cls;
      end
    end
  end
endmodule

// File: rtl/fpd_oldest_pick.sv
module fpd_oldest_pick #(
  parameter int DEPTH = 16,
  parameter int AGE_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][AGE_W-1:0] age,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);
  logic [AGE_W-1:0] best;
  logic [AGE_W-1:0] diff;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    diff  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      diff = age[i] - best;
      if (cand[i] && (!found || diff[AGE_W-1])) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = age[i];
      end
    end
  end
endmodule

// File: rtl/fpd_dispatch.sv
module fpd_dispatch #(
  parameter int DEPTH = 16,
  parameter int AGE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NP    = fpd_pkg::NPORT,
  localparam int CW    = fpd_pkg::CLS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [AGE_W-1:0]    wr_age,
  input  logic [CW-1:0]       wr_cls,
  input  logic                wr_rdy,
  input  logic [DEPTH-1:0]    wake_vec,
  output logic [NP-1:0]       iss_vld,
  output logic [NP*IDX_W-1:0] iss_idx,
  output logic [NP*CW-1:0]    iss_cls,
  output logic                err
);
  import fpd_pkg::*;

  logic [DEPTH-1:0]            vld_q, rdy_q;
  logic [DEPTH-1:0][AGE_W-1:0] age_q;
  logic [DEPTH-1:0][CW-1:0]    cls_q;
  logic [DEPTH-1:0]            port_ok [NP];
  logic [DEPTH-1:0]            taken   [NP+1];
  logic [NP-1:0]               pick_found;
  logic [IDX_W-1:0]            pick_idx [NP];
  logic                        wr_legal;

  assign wr_legal = |legal_ports(wr_cls);

  fpd_entry_store #(.DEPTH(DEPTH), .AGE_W(AGE_W), .CLS_W(CW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en && wr_legal), .wr_idx(wr_idx), .wr_age(wr_age),
    .wr_cls(wr_cls), .wr_rdy(wr_rdy), .wake_vec(wake_vec),
    .clr_vec(taken[NP]),
    .vld_q(vld_q), .rdy_q(rdy_q), .age_q(age_q), .cls_q(cls_q)
  );

  always_comb begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < DEPTH; i++)
        port_ok[p][i] = legal_ports(cls_q[i])[p];
  end

  assign taken[0] = '0;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] onehot;
    assign cand = vld_q & rdy_q & port_ok[p] & ~taken[p];

    fpd_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_pick (
      .cand(cand), .age(age_q), .found(pick_found[p]), .idx(pick_idx[p])
    );

    assign onehot       = pick_found[p] ? (DEPTH'(1) << pick_idx[p]) : '0;
    assign taken[p + 1] = taken[p] | onehot;

    always_ff @(posedge clk) begin
      if (rst) begin
        iss_vld[p]                 <= 1'b0;
        iss_idx[p*IDX_W +: IDX_W]  <= '0;
        iss_cls[p*CW +: CW]        <= '0;
      end else begin
        iss_vld[p]                 <= pick_found[p];
        iss_idx[p*IDX_W +: IDX_W]  <= pick_idx[p];
        iss_cls[p*CW +: CW]        <= cls_q[pick_idx[p]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else if (wr_en && !wr_legal) err <= 1'b1;
  end
endmodule

// File: rtl/fpd_dispatch_chk.sv
module fpd_dispatch_chk #(
  parameter int IDX_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [3:0]         wr_cls,
  input logic [3:0]         iss_vld,
  input logic [4*IDX_W-1:0] iss_idx,
  input logic [15:0]        iss_cls,
  input logic               err
);
  logic [IDX_W-1:0] i0, i1, i2, i3;
  logic [3:0]       c0, c1, c2, c3;
  assign {i3, i2, i1, i0} = iss_idx;
  assign {c3, c2, c1, c0} = iss_cls;

  a_r1_distinct_slots: assert property (@(posedge clk) disable iff (rst)
    !((iss_vld[0] && iss_vld[1] && i0 == i1) || (iss_vld[0] && iss_vld[2] && i0 == i2) ||
      (iss_vld[0] && iss_vld[3] && i0 == i3) || (iss_vld[1] && iss_vld[2] && i1 == i2) ||
      (iss_vld[1] && iss_vld[3] && i1 == i3) || (iss_vld[2] && iss_vld[3] && i2 == i3)));

  a_r2_port0_classes: assert property (@(posedge clk) disable iff (rst)
    iss_vld[0] |-> (c0 <= 4'd4));

  a_r3_port1_classes: assert property (@(posedge clk) disable iff (rst)
    iss_vld[1] |-> (c1 <= 4'd2 || c1 == 4'd5 || c1 == 4'd6));

  a_r4_port2_classes: assert property (@(posedge clk) disable iff (rst)
    iss_vld[2] |-> (c2 >= 4'd7 && c2 <= 4'd9));

  a_r5_port3_classes: assert property (@(posedge clk) disable iff (rst)
    iss_vld[3] |-> (c3 >= 4'd7 && c3 <= 4'd10));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(wr_en && wr_cls > 4'd10));
endmodule

bind fpd_dispatch fpd_dispatch_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cls(wr_cls),
  .iss_vld(iss_vld), .iss_idx(iss_idx), .iss_cls(iss_cls), .err(err)
);

// File: tb/fpd_dispatch_bench.sv
module fpd_dispatch_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int AGE_W  = 8;
  localparam int IW     = 4;

  logic             clk = 0, rst = 1;
  logic             wr_en = 0, wr_rdy = 0;
  logic [IW-1:0]    wr_idx = '0;
  logic [AGE_W-1:0] wr_age = '0;
  logic [3:0]       wr_cls = '0;
  logic [DEPTH-1:0] wake_vec = '0;
  logic [3:0]       iss_vld;
  logic [4*IW-1:0]  iss_idx;
  logic [15:0]      iss_cls;
  logic             err;

  fpd_dispatch #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_fpd_dispatch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_age(wr_age),
    .wr_cls(wr_cls), .wr_rdy(wr_rdy), .wake_vec(wake_vec),
    .iss_vld(iss_vld), .iss_idx(iss_idx), .iss_cls(iss_cls), .err(err));

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed { logic [3:0] v; logic [15:0] idx; logic [15:0] cls; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model of the window
  bit             m_vld [DEPTH], m_rdy [DEPTH];
  bit [AGE_W-1:0] m_age [DEPTH];
  bit [3:0]       m_cls [DEPTH];
  bit             m_err;
  bit [AGE_W-1:0] age_ctr;

  function automatic bit accepts(int p, bit [3:0] c);
    case (p)
      0: return c <= 4;                       // R2
      1: return c <= 2 || c == 5 || c == 6;   // R3
      2: return c >= 7 && c <= 9;             // R4
      default: return c >= 7 && c <= 10;      // R5
    endcase
  endfunction

  function automatic bit older(bit [AGE_W-1:0] a, bit [AGE_W-1:0] b);
    bit [AGE_W-1:0] d = a - b;                // R7 modular compare
    return d[AGE_W-1];
  endfunction

  function automatic string tag(int p);
    case (p)
      0: return "R2 R6"; 1: return "R3 R6"; 2: return "R4 R6"; default: return "R5 R6";
    endcase
  endfunction

  // compute expected picks (R1, R6) from the current model state
  task automatic predict(output exp_t e);
    bit tk [DEPTH];
    e = '0;
    for (int i = 0; i < DEPTH; i++) tk[i] = 0;
    for (int p = 0; p < 4; p++) begin
      int b = -1;
      for (int i = 0; i < DEPTH; i++)
        if (m_vld[i] && m_rdy[i] && !tk[i] && accepts(p, m_cls[i]))
          if (b < 0 || older(m_age[i], m_age[b])) b = i;
      if (b >= 0) begin
        tk[b] = 1;
        e.v[p] = 1'b1;
        e.idx[p*4 +: 4] = 4'(b);
        e.cls[p*4 +: 4] = m_cls[b];
      end
    end
  endtask

  task automatic compare();
    exp_t e = sb.pop_front();
    for (int p = 0; p < 4; p++) begin
      bit ok = (iss_vld[p] == e.v[p]) &&
               (!e.v[p] || (iss_idx[p*4 +: 4] == e.idx[p*4 +: 4] &&
                            iss_cls[p*4 +: 4] == e.cls[p*4 +: 4]));
      n_chk++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s R1 R8 R11 port%0d: got v=%0d idx=%0d cls=%0d expected v=%0d idx=%0d cls=%0d",
                 tag(p), p, iss_vld[p], iss_idx[p*4 +: 4], iss_cls[p*4 +: 4],
                 e.v[p], e.idx[p*4 +: 4], e.cls[p*4 +: 4]);
      end
    end
    n_chk++;
    if (err !== m_err) begin
      n_bad++;
      $display("FAIL R9 err: got %0d expected %0d", err, m_err);
    end
  endtask

  task automatic rand_cls(input int phase, output bit [3:0] c);
    int r = $urandom_range(0, 99);
    case (phase)
      0: c = 4'($urandom_range(0, 6));                    // arithmetic heavy
      1: c = 4'($urandom_range(7, 10));                   // vector heavy
      default: c = (phase == 4 && r < 6) ? 4'($urandom_range(11, 15))
                                         : 4'($urandom_range(0, 10));
    endcase
  endtask

  initial begin
    exp_t e;
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_rdy[i] = 0; end
    m_err = 0;
    age_ctr = 8'hF0;                                      // R7: wraps early
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    n_chk++;
    if (iss_vld !== 4'b0 || err !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: got vld=%b err=%0d expected vld=0000 err=0", iss_vld, err);
    end
    rst = 0;
    sb.push_back('0);
    for (int cyc = 0; cyc < 5000; cyc++) begin
      int phase = cyc / 1000;
      int free = -1;
      bit do_wr, rdy_in;
      bit [3:0] c;
      bit [DEPTH-1:0] wk;
      @(negedge clk);
      compare();
      predict(e);
      sb.push_back(e);                                    // R11 one-edge latency
      // R8: picked entries leave at the coming edge
      for (int p = 0; p < 4; p++) if (e.v[p]) m_vld[e.idx[p*4 +: 4]] = 0;
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) free = i;
      rand_cls(phase, c);
      do_wr  = (free >= 0) && ($urandom_range(0, 9) < 8);
      if (phase == 3) begin                               // hold then release
        rdy_in = 0;
        wk = ((cyc % 40) == 39) ? '1 : '0;
      end else begin
        rdy_in = $urandom_range(0, 2) != 0;
        wk = DEPTH'($urandom) & DEPTH'($urandom);
      end
      for (int i = 0; i < DEPTH; i++) if (m_vld[i] && wk[i]) m_rdy[i] = 1;
      if (do_wr) begin
        if (c > 10) m_err = 1;                            // R9
        else begin
          m_vld[free] = 1; m_rdy[free] = rdy_in;
          m_age[free] = age_ctr; m_cls[free] = c;
        end
        age_ctr++;
      end
      wr_en = do_wr; wr_idx = 4'(free < 0 ? 0 : free); wr_age = age_ctr - 8'(do_wr);
      wr_cls = c; wr_rdy = rdy_in; wake_vec = wk;
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule